// File: doc/BRIEF.md
# DMA Command-Queue Register Block

This block is the register file that software uses to drive a DMA engine's command queue. A 32-bit register bus reaches it. Each write takes one clock cycle, and a read returns data in the same cycle with no wait states. The block holds the queue base, the end pointer, the write pointer, the read pointer, an interrupt enable word and an interrupt status word. It also drives one level interrupt line.

The block does not move data. It treats a command as finished at the moment software writes the write pointer. At that point the read pointer takes the new write-pointer value, and both completion flags in the status word are set. Software can suppress one completion ahead of time by writing a key value to the read-pointer offset. This arms a one-shot flag, and the next write-pointer update then clears the flag and raises no flags.

Top module: `dmaq_regfile`

## Requirements
- R1: After reset every word reads 0, except the status word at byte offset 0x24, which reads 0xF8000000. The interrupt output is low and the one-shot flag is clear.
- R2: A write to the end pointer (offset 0x14) or to the write pointer (offset 0x18) stores only bits [17:0]. Bits [31:18] of both words read as 0.
- R3: A write to the write pointer (0x18) also loads the same masked value into the read pointer (offset 0x1C).
- R4: Writes to the read-pointer offset 0x1C never change the read pointer. Writing exactly 0xEE882266 there arms the one-shot flag, and any other value has no effect at all.
- R5: A write-pointer write while the flag is armed clears the flag and leaves the status word and the interrupt unchanged. The next write-pointer write then completes normally.
- R6: A write-pointer write while the flag is clear sets status bits 4 and 5 (upstream and downstream done). From the next cycle the interrupt is high if enable bit 4 or enable bit 5 (offset 0x20) is set.
- R7: A write to the enable word (0x20) stores the value ANDed with 0xBFEFF07F.
- R8: A status write (0x24) with bit 4 or bit 5 set clears both bits and drives the interrupt low. Every other status bit keeps its value, and a status write with both bits clear changes nothing.
- R9: Writes to any other word offset in the 64-byte window, including the queue base at 0x10, store all 32 bits. A read returns the word at the presented address in the same cycle.
- R10: A write whose byte address has bits [1:0] not equal to 0 is ignored.
- R11: The interrupt is a registered level. A write to the enable word alone never changes it, and a completion while bits 4 and 5 of the enable word are both clear leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The bound checker evaluates the following on every cycle: pointer masking, the copy into the read pointer, read-pointer immutability, flag consumption, the setting and clearing of the completion bits, and the rule that the interrupt rises only after a write-pointer write and holds still across enable writes. Some behaviours need a sequence of writes before they show, and only the bench scenarios can show them. These are: a key that is armed and then consumed after unrelated writes, a near-miss key that arms nothing, the interrupt staying low when a completion happens with the enables off, and the full-width storage of the general words. Each scenario is followed by a full read-back of the window.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
   // word indices whose behaviour neighbours depend on
   localparam int unsigned WD_BASE = 4;
   localparam int unsigned WD_END  = 5;
   localparam int unsigned WD_WP   = 6;
   localparam int unsigned WD_RP   = 7;
   localparam int unsigned WD_EN   = 8;
   localparam int unsigned WD_ST   = 9;
   localparam int unsigned WD_LAST = WD_ST;

   localparam logic [31:0] ARM_KEY     = 32'hEE88_2266;
   localparam logic [31:0] EN_MASK_DEF = 32'hBFEF_F07F;
   localparam logic [31:0] ST_RESET    = 32'hF800_0000;
   localparam logic [31:0] DONE_BITS   = 32'h0000_0030;

   function automatic bit is_special(int unsigned idx);
      return (idx >= WD_END) && (idx <= WD_ST);
   endfunction
endpackage

// File: rtl/dmaq_decode.sv
module dmaq_decode #(
   parameter int unsigned NUM_WORDS = 16,
   localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
   localparam int unsigned ADDR_W   = IDX_W + 2
) (
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_WORDS-1:0] wr_word
);
   logic             aligned;
   logic [IDX_W-1:0] widx;

   assign aligned = (addr[1:0] == 2'b00);
   assign widx    = addr[ADDR_W-1:2];

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_hit
      assign wr_word[i] = we && aligned && (widx == IDX_W'(i));
   end
endmodule

// File: rtl/dmaq_ptr_ctl.sv
module dmaq_ptr_ctl
   import dmaq_pkg::*;
#(
   parameter int unsigned PTR_W = 18,
   localparam logic [31:0] PTR_MASK = (PTR_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << PTR_W) - 32'd1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_end,
   input  logic        wr_wp,
   input  logic        wr_rp,
   input  logic [31:0] wdata,
   output logic [31:0] end_q,
   output logic [31:0] wp_q,
   output logic [31:0] rp_q,
   output logic        arm_q,
   output logic        done_evt
);
   logic [31:0] masked;
   assign masked   = wdata & PTR_MASK;
   // a completion fires on a write-pointer update unless the flag is armed
   assign done_evt = wr_wp && !arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         end_q <= '0;
         wp_q  <= '0;
         rp_q  <= '0;
         arm_q <= 1'b0;
      end else begin
         if (wr_end) end_q <= masked;
         if (wr_wp) begin
            wp_q  <= masked;
            rp_q  <= masked;
            arm_q <= 1'b0;
         end else if (wr_rp && (wdata == ARM_KEY)) begin
            arm_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dmaq_irq_ctl.sv
module dmaq_irq_ctl
   import dmaq_pkg::*;
#(
   parameter logic [31:0] EN_MASK = EN_MASK_DEF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        wr_st,
   input  logic        done_evt,
   input  logic [31:0] wdata,
   output logic [31:0] en_q,
   output logic [31:0] st_q,
   output logic        irq_o
);
   logic clr_req;
   logic en_any;

   assign clr_req = wr_st && ((wdata & DONE_BITS) != '0);
   assign en_any  = (en_q & DONE_BITS) != '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         st_q  <= ST_RESET;
         irq_o <= 1'b0;
      end else begin
         if (wr_en) en_q <= wdata & EN_MASK;
         if (done_evt) begin
            st_q <= st_q | DONE_BITS;
            if (en_any) irq_o <= 1'b1;
         end else if (clr_req) begin
            st_q  <= st_q & ~DONE_BITS;
            irq_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dmaq_gp_store.sv
module dmaq_gp_store
   import dmaq_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WORDS-1:0] wr_word,
   input  logic [31:0]          wdata,
   output logic [31:0]          words [NUM_WORDS]
);
   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      if (is_special(i)) begin : g_owned_elsewhere
         assign words[i] = '0;
      end else begin : g_plain
         logic [31:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q <= '0;
            else if (wr_word[i]) q <= wdata;
         end
         assign words[i] = q;
      end
   end
endmodule

// File: rtl/dmaq_regfile.sv
module dmaq_regfile
   import dmaq_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 16,
   parameter int unsigned PTR_W     = 18,
   parameter logic [31:0] EN_MASK   = EN_MASK_DEF,
   localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
   localparam int unsigned ADDR_W   = IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_o
);
   if (NUM_WORDS <= WD_LAST || (NUM_WORDS & (NUM_WORDS - 1)) != 0) begin : g_bad_depth
      $error("NUM_WORDS must be a power of two above the last fixed word");
   end
   if (PTR_W < 1 || PTR_W > 32) begin : g_bad_ptr
      $error("PTR_W must lie in 1..32");
   end

   logic [NUM_WORDS-1:0] wr_word;
   logic [31:0] end_q, wp_q, rp_q, en_q, st_q;
   logic        arm_q, done_evt;
   logic [31:0] gp_words [NUM_WORDS];
   logic [IDX_W-1:0] ridx;

   dmaq_decode #(.NUM_WORDS(NUM_WORDS)) u_dec (
      .we(bus_we), .addr(bus_addr), .wr_word(wr_word)
   );

   dmaq_ptr_ctl #(.PTR_W(PTR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .wr_end(wr_word[WD_END]), .wr_wp(wr_word[WD_WP]), .wr_rp(wr_word[WD_RP]),
      .wdata(bus_wdata),
      .end_q(end_q), .wp_q(wp_q), .rp_q(rp_q), .arm_q(arm_q), .done_evt(done_evt)
   );

   dmaq_irq_ctl #(.EN_MASK(EN_MASK)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_word[WD_EN]), .wr_st(wr_word[WD_ST]), .done_evt(done_evt),
      .wdata(bus_wdata),
      .en_q(en_q), .st_q(st_q), .irq_o(irq_o)
   );

   dmaq_gp_store #(.NUM_WORDS(NUM_WORDS)) u_gp (
      .clk(clk), .rst_n(rst_n), .wr_word(wr_word), .wdata(bus_wdata), .words(gp_words)
   );

   assign ridx = bus_addr[ADDR_W-1:2];

   always_comb begin
      unique case (ridx)
         IDX_W'(WD_END): bus_rdata = end_q;
         IDX_W'(WD_WP):  bus_rdata = wp_q;
         IDX_W'(WD_RP):  bus_rdata = rp_q;
         IDX_W'(WD_EN):  bus_rdata = en_q;
         IDX_W'(WD_ST):  bus_rdata = st_q;
         default:        bus_rdata = gp_words[ridx];
      endcase
   end
endmodule

// File: rtl/dmaq_regfile_chk.sv
module dmaq_regfile_chk
   import dmaq_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 16,
   parameter int unsigned PTR_W     = 18,
   parameter logic [31:0] EN_MASK   = EN_MASK_DEF,
   localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
   localparam int unsigned ADDR_W   = IDX_W + 2,
   localparam logic [31:0] PMASK    = (PTR_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << PTR_W) - 32'd1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic [31:0]       end_q,
   input logic [31:0]       wp_q,
   input logic [31:0]       rp_q,
   input logic [31:0]       en_q,
   input logic [31:0]       st_q,
   input logic              arm_q,
   input logic              irq_o
);
   logic ok, hit_end, hit_wp, hit_rp, hit_en, hit_st;
   assign ok      = we && (addr[1:0] == 2'b00);
   assign hit_end = ok && (addr[ADDR_W-1:2] == IDX_W'(WD_END));
   assign hit_wp  = ok && (addr[ADDR_W-1:2] == IDX_W'(WD_WP));
   assign hit_rp  = ok && (addr[ADDR_W-1:2] == IDX_W'(WD_RP));
   assign hit_en  = ok && (addr[ADDR_W-1:2] == IDX_W'(WD_EN));
   assign hit_st  = ok && (addr[ADDR_W-1:2] == IDX_W'(WD_ST));

   AST_END_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      hit_end |=> end_q == ($past(wdata) & PMASK)); // R2
   AST_WP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      hit_wp |=> wp_q == ($past(wdata) & PMASK)); // R2
   AST_RP_FOLLOWS_WP: assert property (@(posedge clk) disable iff (!rst_n)
      hit_wp |=> rp_q == wp_q); // R3
   AST_RP_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_rp |=> $stable(rp_q)); // R4
   AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wp && arm_q) |=> !arm_q && $stable(st_q) && $stable(irq_o)); // R5
   AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wp && !arm_q) |=> (st_q & DONE_BITS) == DONE_BITS); // R6
   AST_EN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      hit_en |=> en_q == ($past(wdata) & EN_MASK)); // R7
   AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_st && (wdata & DONE_BITS) != '0) |=> !irq_o && (st_q & DONE_BITS) == '0); // R8
   AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(hit_wp)); // R11
   AST_EN_NO_IRQ_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      hit_en |=> $stable(irq_o)); // R11
endmodule

bind dmaq_regfile dmaq_regfile_chk #(
   .NUM_WORDS(NUM_WORDS), .PTR_W(PTR_W), .EN_MASK(EN_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
   .end_q(end_q), .wp_q(wp_q), .rp_q(rp_q), .en_q(en_q), .st_q(st_q),
   .arm_q(arm_q), .irq_o(irq_o)
);

// File: tb/sim_dmaq_regfile.sv
module sim_dmaq_regfile;
   localparam int NW = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;

   // behavioural reference
   int unsigned mreg [NW];
   bit          marm;
   bit          mirq;

   always #4 clk = ~clk;

   dmaq_regfile u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   task automatic model_reset();
      for (int i = 0; i < NW; i++) mreg[i] = 0;
      mreg[9] = 32'hF800_0000;
      marm = 0;
      mirq = 0;
   endtask

   task automatic model_write(input int unsigned a, input int unsigned d);
      int unsigned k;
      if ((a & 3) != 0) return;              // R10
      k = a >> 2;
      case (k)
         5: mreg[5] = d & 32'h3FFFF;         // R2
         6: begin                            // R2 R3 R5 R6
            mreg[6] = d & 32'h3FFFF;
            mreg[7] = mreg[6];
            if (marm) marm = 0;
            else begin
               mreg[9] = mreg[9] | 32'h30;
               if ((mreg[8] & 32'h30) != 0) mirq = 1;
            end
         end
         7: if (d == 32'hEE88_2266) marm = 1; // R4
         8: mreg[8] = d & 32'hBFEF_F07F;     // R7
         9: if ((d & 32'h30) != 0) begin     // R8
            mreg[9] = mreg[9] & ~32'h30;
            mirq = 0;
         end
         default: mreg[k] = d;               // R9
      endcase
   endtask

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one bus write: drive at negedge, compare interrupt after the edge
   task automatic wr(input string tag, input int unsigned a, input int unsigned d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = d;
      model_write(a, d);
      @(posedge clk);
      #2;
      bus_we = 1'b0;
      check(tag, "irq", {31'b0, irq_o}, {31'b0, mirq});
   endtask

   task automatic readback(input string tag);
      for (int i = 0; i < NW; i++) begin
         bus_addr = 6'(i * 4);
         #1;
         check(tag, $sformatf("word%0d", i), bus_rdata, mreg[i]);
      end
      check(tag, "irq", {31'b0, irq_o}, {31'b0, mirq});
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #2 readback("R1");

      // general words full width
      wr("R9", 32'h10, 32'hDEAD_BEEF);
      wr("R9", 32'h00, 32'hFFFF_FFFF);
      wr("R9", 32'h3C, 32'h1234_5678);
      readback("R9");

      // misaligned writes dropped
      wr("R10", 32'h11, 32'h0);
      wr("R10", 32'h1B, 32'h0000_0ABC);
      wr("R10", 32'h26, 32'hFFFF_FFFF);
      readback("R10");

      // pointer masking
      wr("R2", 32'h14, 32'hFFFF_FFFF);
      readback("R2");

      // enable masking, no interrupt effect
      wr("R7", 32'h20, 32'hFFFF_FFFF);
      readback("R7");
      wr("R7", 32'h20, 32'h0);

      // completion with interrupts off
      wr("R6", 32'h18, 32'hFFF1_2345);
      readback("R6");
      wr("R11", 32'h20, 32'h30);
      readback("R11");

      // clear with bit 4 only, then a no-op status write
      wr("R8", 32'h24, 32'h10);
      readback("R8");
      wr("R8", 32'h24, 32'hFFFF_FFCF);
      readback("R8");

      // completion with bit 4 enabled raises the line
      wr("R6", 32'h20, 32'h10);
      wr("R6", 32'h18, 32'h0000_0777);
      readback("R6");
      wr("R11", 32'h20, 32'h0);
      readback("R11");
      wr("R8", 32'h24, 32'h20);
      readback("R8");

      // near-miss key arms nothing
      wr("R4", 32'h20, 32'h20);
      wr("R4", 32'h1C, 32'hEE88_2267);
      readback("R4");
      wr("R4", 32'h18, 32'h0000_0100);
      readback("R4");
      wr("R4", 32'h24, 32'h30);

      // key arms, one completion swallowed, next one normal
      wr("R4", 32'h1C, 32'hEE88_2266);
      readback("R4");
      wr("R5", 32'h00, 32'h5555_AAAA);
      wr("R5", 32'h18, 32'h0002_0202);
      readback("R5");
      wr("R5", 32'h18, 32'h0001_0101);
      readback("R5");

      // mixed traffic
      for (int n = 0; n < 400; n++) begin
         int unsigned a, d, sel;
         sel = $urandom_range(0, 9);
         a = (sel < 7) ? (32'h14 + 4 * $urandom_range(0, 4)) : $urandom_range(0, 63);
         d = $urandom();
         if ($urandom_range(0, 5) == 0) d = 32'hEE88_2266;
         wr("R9", a, d);
         if ((n % 8) == 0) readback("R3");
      end
      readback("R3");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule